// File: doc/BRIEF.md
# Sync-Header Block Lock Tracker

This block finds and holds 66-bit block alignment on a 64b/66b receive path. For every block, the upstream header extractor raises a one-cycle strobe. Alongside the strobe it gives a flag that is high when the two-bit sync header is a legal one (01 or 10). The block counts tested headers in fixed windows and counts the bad headers inside each window. From these counts it decides whether alignment is proven, still holding, or lost.

Getting lock is strict: a whole window of headers must arrive with no bad header among them. Once lock is held, the block tolerates some bad headers in each window. Lock drops, and a one-cycle slip request goes to the upstream gearbox, only when the bad-header count in one window reaches its limit. While unlocked, any bad header triggers a slip at once. The window length and the bad-header limit are parameters (defaults 64 and 16).

Top module: `hdr_align_lock`

## Requirements
- R1: While rst_ni is low, and on the first edges after it rises, lock_o and slip_o are 0. An assertion of rst_ni drops lock_o at once, without waiting for a clock edge.
- R2: When unlocked, lock_o rises at the clock edge that samples the WIN_HDRS-th (default 64) strobe of a window, but only if every header in that window had hdr_valid_i=1. lock_o is visible the cycle after that strobe. WIN_HDRS-1 clean headers are not enough.
- R3: When unlocked, a strobe with hdr_valid_i=0 (an illegal header) causes a slip at once and restarts the window. Any clean headers counted before it are discarded.
- R4: When locked, a window of WIN_HDRS headers that holds fewer than INV_LIMIT (default 16) bad headers leaves lock_o at 1 and produces no slip.
- R5: When locked, the INV_LIMIT-th bad header within one window clears lock_o and issues a slip at the same edge.
- R6: slip_o is high for exactly one cycle per slip, and lock_o is 0 in that cycle.
- R7: A strobe that arrives in the slip cycle is ignored. It is not counted toward the new window.
- R8: Without a strobe, lock_o does not change, whatever hdr_valid_i does.
- R9: A window closes on its WIN_HDRS-th tested header. Good and bad headers count alike toward the window. Both counts restart when the window closes, so bad headers do not carry over into the next window.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Receive clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| hdr_strobe_i | input | 1 | One-cycle strobe: a sync header is ready to test |
| hdr_valid_i | input | 1 | 1 when the strobed header is 01 or 10 |
| lock_o | output | 1 | Block alignment achieved |
| slip_o | output | 1 | One-cycle request to shift alignment by one bit |

## Verification
The bench targets the edges of both counters. With 63 clean headers the block must stay unlocked, and the 64th must lock it; an off-by-one window would lock one header early or late. A locked window with exactly 15 bad headers must keep lock, and a window with 16 must drop it. A limit compare that is one off would either drop lock too soon or keep it too long. A window closed by its last header being bad checks that the counts restart, since a carried-over count would break a later window. A strobe during the slip cycle is held high on purpose: a design that counts it would lock one header early or slip twice.

// File: rtl/hdr_align_pkg.sv
`timescale 1ns/1ps
package hdr_align_pkg;

  typedef enum logic [1:0] {
    ST_INIT = 2'd0,
    ST_TEST = 2'd1,
    ST_SLIP = 2'd2
  } align_state_e;

  typedef struct packed {
    logic win_last;   // current header closes the window
    logic inv_last;   // one more bad header reaches the limit
    logic clean;      // no bad header so far in this window
  } cnt_flags_t;

endpackage

// File: rtl/hdr_align_cnt.sv
`timescale 1ns/1ps
module hdr_align_cnt
  import hdr_align_pkg::*;
#(
  parameter int WIN_HDRS  = 64,
  parameter int INV_LIMIT = 16
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       clr_i,
  input  logic       inc_i,
  input  logic       bad_i,
  output cnt_flags_t flags_o
);

  localparam int CW = (WIN_HDRS  > 2) ? $clog2(WIN_HDRS)  : 1;
  localparam int IW = (INV_LIMIT > 2) ? $clog2(INV_LIMIT) : 1;
  localparam logic [CW-1:0] WIN_TOP = CW'(WIN_HDRS - 1);
  localparam logic [IW-1:0] INV_TOP = IW'(INV_LIMIT - 1);

  logic [CW-1:0] hdr_q;
  logic [IW-1:0] inv_q;

  // clear wins over increment: the closing header is never stored
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hdr_q <= '0;
      inv_q <= '0;
    end else if (clr_i) begin
      hdr_q <= '0;
      inv_q <= '0;
    end else if (inc_i) begin
      hdr_q <= hdr_q + CW'(1);
      inv_q <= inv_q + IW'(bad_i);
    end
  end

  always_comb begin
    flags_o.win_last = (hdr_q == WIN_TOP);
    flags_o.inv_last = (inv_q == INV_TOP);
    flags_o.clean    = (inv_q == '0);
  end

endmodule

// File: rtl/hdr_align_ctrl.sv
`timescale 1ns/1ps
module hdr_align_ctrl
  import hdr_align_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       strobe_i,
  input  logic       valid_i,
  input  cnt_flags_t flags_i,
  output logic       cnt_clr_o,
  output logic       cnt_inc_o,
  output logic       lock_o,
  output logic       slip_o
);

  align_state_e state_q, state_d;
  logic         lock_q, lock_d;

  always_comb begin
    state_d   = state_q;
    lock_d    = lock_q;
    cnt_clr_o = 1'b0;
    cnt_inc_o = 1'b0;
    unique case (state_q)
      ST_INIT: begin
        cnt_clr_o = 1'b1;
        state_d   = ST_TEST;
      end
      ST_TEST: begin
        if (strobe_i) begin
          cnt_inc_o = 1'b1;
          if (valid_i) begin
            if (flags_i.win_last) begin
              cnt_clr_o = 1'b1;
              if (flags_i.clean) lock_d = 1'b1;
            end
          end else if (flags_i.inv_last || !lock_q) begin
            state_d   = ST_SLIP;
            lock_d    = 1'b0;
            cnt_clr_o = 1'b1;
          end else if (flags_i.win_last) begin
            cnt_clr_o = 1'b1;
          end
        end
      end
      ST_SLIP: state_d = ST_TEST;  // gearbox shifting; strobe ignored
      default: state_d = ST_INIT;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_INIT;
      lock_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      lock_q  <= lock_d;
    end
  end

  assign lock_o = lock_q;
  assign slip_o = (state_q == ST_SLIP);

endmodule

// File: rtl/hdr_align_lock.sv
`timescale 1ns/1ps
module hdr_align_lock
  import hdr_align_pkg::*;
#(
  parameter int WIN_HDRS  = 64,
  parameter int INV_LIMIT = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hdr_strobe_i,
  input  logic hdr_valid_i,
  output logic lock_o,
  output logic slip_o
);

  cnt_flags_t flags;
  logic       cnt_clr, cnt_inc;

  hdr_align_cnt #(
    .WIN_HDRS (WIN_HDRS),
    .INV_LIMIT(INV_LIMIT)
  ) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (cnt_clr),
    .inc_i  (cnt_inc),
    .bad_i  (~hdr_valid_i),
    .flags_o(flags)
  );

  hdr_align_ctrl u_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .strobe_i (hdr_strobe_i),
    .valid_i  (hdr_valid_i),
    .flags_i  (flags),
    .cnt_clr_o(cnt_clr),
    .cnt_inc_o(cnt_inc),
    .lock_o   (lock_o),
    .slip_o   (slip_o)
  );

endmodule

// File: rtl/hdr_align_lock_chk.sv
`timescale 1ns/1ps
module hdr_align_lock_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic hdr_strobe_i,
  input logic hdr_valid_i,
  input logic lock_o,
  input logic slip_o
);

  a_r6_slip_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    slip_o |=> !slip_o);

  a_r6_slip_unlocked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    slip_o |-> !lock_o);

  a_r3_slip_after_bad_hdr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    slip_o |-> $past(hdr_strobe_i && !hdr_valid_i));

  a_r2_lock_rise_on_good_hdr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(lock_o) |-> $past(hdr_strobe_i && hdr_valid_i));

  a_r5_lock_fall_with_slip: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(lock_o) |-> slip_o);

  a_r8_hold_without_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(hdr_strobe_i) |-> $stable(lock_o));

endmodule

bind hdr_align_lock hdr_align_lock_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .hdr_strobe_i(hdr_strobe_i),
  .hdr_valid_i (hdr_valid_i),
  .lock_o      (lock_o),
  .slip_o      (slip_o)
);

// File: tb/tb_hdr_align_lock.sv
`timescale 1ns/1ps
module tb_hdr_align_lock;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic strobe = 1'b0;
  logic valid = 1'b0;
  logic lock, slip;

  int n_chk = 0;
  int n_fail = 0;
  int slips = 0;
  bit done = 0;

  always #4 clk = ~clk;  // 125 MHz

  hdr_align_lock dut (
    .clk_i       (clk),
    .rst_ni      (rst_ni),
    .hdr_strobe_i(strobe),
    .hdr_valid_i (valid),
    .lock_o      (lock),
    .slip_o      (slip)
  );

  // n headers; every k-th one bad (0 = all good); expected lock and slip count at the end
  typedef struct packed {
    logic [7:0] n;
    logic [7:0] every;
    logic       lock;
    logic [6:0] slips;
  } seg_t;

  localparam int SEG_N = 14;
  localparam seg_t SEGS [SEG_N] = '{
    '{8'd63, 8'd0,  1'b0, 7'd0},  // R2 one short of a window
    '{8'd1,  8'd0,  1'b1, 7'd0},  // R2 window complete
    '{8'd64, 8'd8,  1'b1, 7'd0},  // R4 8 bad
    '{8'd60, 8'd4,  1'b1, 7'd0},  // R9 15 bad, window open
    '{8'd4,  8'd0,  1'b1, 7'd0},  // R9 window closes at 15 bad
    '{8'd64, 8'd4,  1'b0, 7'd1},  // R5 16th bad on last header
    '{8'd10, 8'd2,  1'b0, 7'd5},  // R3 every bad slips
    '{8'd64, 8'd0,  1'b1, 7'd0},  // R2 relock
    '{8'd64, 8'd64, 1'b1, 7'd0},  // R4 bad header closes window
    '{8'd32, 8'd2,  1'b0, 7'd1},  // R5 16 bad in 32 headers
    '{8'd30, 8'd0,  1'b0, 7'd0},  // R3 partial clean run
    '{8'd1,  8'd1,  1'b0, 7'd1},  // R3 bad discards the run
    '{8'd63, 8'd0,  1'b0, 7'd0},  // R2 count restarted
    '{8'd1,  8'd0,  1'b1, 7'd0}   // R2
  };

  function automatic string seg_tag(int i);
    case (i)
      2, 8:       return "R4";
      3, 4:       return "R9";
      5, 9:       return "R5";
      6, 10, 11:  return "R3";
      default:    return "R2";
    endcase
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // one header, then one idle cycle (covers a slip cycle)
  task automatic send(bit good);
    @(negedge clk);
    strobe = 1'b1;
    valid  = good;
    @(negedge clk);
    strobe = 1'b0;
    valid  = 1'b0;
    if (slip) slips++;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    // R1 reset state
    repeat (3) @(negedge clk);
    check("R1 lock in reset", 32'(lock), 0);
    check("R1 slip in reset", 32'(slip), 0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk);
    check("R1 lock after reset", 32'(lock), 0);
    check("R1 slip after reset", 32'(slip), 0);

    for (int s = 0; s < SEG_N; s++) begin
      slips = 0;
      for (int h = 1; h <= int'(SEGS[s].n); h++)
        send(!(SEGS[s].every != 0 && (h % int'(SEGS[s].every)) == 0));
      check({seg_tag(s), " lock"}, 32'(lock), 32'(SEGS[s].lock));
      check({seg_tag(s), " slips"}, 32'(slips), 32'(SEGS[s].slips));
    end

    // R8: valid toggles without strobe, locked state held
    slips = 0;
    for (int c = 0; c < 20; c++) begin
      @(negedge clk);
      valid = c[0];
      if (slip) slips++;
    end
    valid = 1'b0;
    check("R8 lock held", 32'(lock), 1);
    check("R8 no slip", 32'(slips), 0);

    // R1 asynchronous drop of lock
    #1 rst_ni = 1'b0;
    #1 check("R1 async lock drop", 32'(lock), 0);
    @(negedge clk);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk);

    // R6/R7: bad header, strobe held high into the slip cycle
    strobe = 1'b1;
    valid  = 1'b0;
    @(negedge clk);
    check("R6 slip asserted", 32'(slip), 1);
    check("R6 lock low in slip", 32'(lock), 0);
    valid = 1'b1;  // strobe during slip cycle
    @(negedge clk);
    strobe = 1'b0;
    valid  = 1'b0;
    check("R6 slip one cycle", 32'(slip), 0);
    check("R7 no second slip", 32'(slip), 0);
    slips = 0;
    for (int h = 0; h < 63; h++) send(1'b1);
    check("R7 ignored strobe not counted", 32'(lock), 0);
    send(1'b1);
    check("R7 lock on 64th", 32'(lock), 1);
    check("R7 no slips", 32'(slips), 0);

    repeat (2) @(negedge clk);
    finish_run();
  end

endmodule